// File: doc/BRIEF.md
# Arbitrating I2C Master Byte Engine

This block is the byte-level data engine of an I2C master that may share the bus with other masters. It drives SDA through a single open-drain style output (high means pull the line low). It watches the resolved bus level through a two-flop synchronized input. A companion clock block owns SCL and hands this engine two one-cycle strobes. One marks the moment SCL has just fallen, the other the moment SCL has just risen. The engine changes its SDA drive only on the falling strobe, apart from the START and STOP edges, which it places while SCL is high. It samples the bus only on the rising strobe.

A host issues one command at a time: START, STOP, write a byte, or read a byte with a chosen acknowledge answer. Every command ends with a one-cycle done pulse. A write also reports whether the target acknowledged. A read returns the captured byte. While shifting out a write byte, the engine compares each bit it releases with the wired-AND level it reads back. If it released the line and finds it low, another master has won. The engine then releases SDA for good, ends the command, and raises a sticky lost-arbitration flag. The flag stays set until the next START command.

Top module: `i2c_arb_master`

## Requirements
- R1: While reset is asserted and right after it, sda_drive_low, busy, done and arb_lost are all 0.
- R2: A START command (cmd_op 0) releases SDA on the next fall strobe and pulls it low on the following rise strobe. SDA is therefore high when SCL rises and falls while SCL is high. After done, sda_drive_low is 1.
- R3: sda_drive_low changes only in the cycle after a fall strobe. The one exception is the cycle after a rise strobe during a START or STOP command.
- R4: A write command (cmd_op 2) places cmd_byte on SDA most significant bit first. There is one bit per SCL period, and each bit is held for the whole SCL high time: a 1 releases the line and a 0 pulls it low.
- R5: On the ninth SCL period of a write, the engine releases SDA. ack_rcvd is 1 when the bus is low at that rise strobe (ACK) and 0 when it is high (NAK).
- R6: A read command (cmd_op 3) releases SDA for eight SCL periods. It captures the bus level at each rise strobe, most significant bit first, into rx_byte. The level is seen through a two-flop synchronizer.
- R7: On the ninth SCL period of a read, the engine pulls SDA low when cmd_nak is 0 (ACK) and releases it when cmd_nak is 1 (NAK).
- R8: A STOP command (cmd_op 1) pulls SDA low on the next fall strobe and releases it on the following rise strobe. SDA therefore rises while SCL is high. After done, sda_drive_low is 0.
- R9: During a write, if the engine is releasing SDA for a bit and reads it low at the rise strobe, it sets arb_lost, pulses done, returns to idle with SDA released, and drives none of the remaining bits. A low bus on a bit it is driving low is not a loss.
- R10: arb_lost stays set through later write, read and STOP commands. Only the acceptance of a START command clears it.
- R11: Each command produces exactly one done pulse, one cycle long, and done coincides with busy falling. A cmd_valid presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_fall_stb | input | 1 | One-cycle strobe: SCL has just fallen |
| scl_rise_stb | input | 1 | One-cycle strobe: SCL has just risen |
| sda_in | input | 1 | Raw resolved SDA bus level |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_byte | input | DATA_W | Byte to transmit on a write |
| cmd_nak | input | 1 | Read answer: 0 ACK, 1 NAK |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command end |
| ack_rcvd | output | 1 | Target acknowledged the last written byte |
| rx_byte | output | DATA_W | Last byte shifted in |
| arb_lost | output | 1 | Sticky lost-arbitration flag |

## Verification
The drive output moves on the clock edge that sees a fall strobe, so the bus follows one cycle later. The sampled level is two synchronizer cycles behind the bus. The bench therefore leaves five idle cycles between each strobe and the next, and records the bus level in the cycle that raises the rise strobe. done, ack_rcvd, rx_byte and arb_lost all update on the edge that sees the final rise strobe. The bench reads them on the following falling clock edge. It sweeps every byte value for both write and read, with the acknowledge pattern and the read answer computed from the byte itself. It also forces an arbitration loss on a chosen bit and watches the drive stay released over later SCL periods.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_REL,
    S_ST_LOW,
    S_BIT_SET,
    S_BIT_SAMP,
    S_ACK_SET,
    S_ACK_SAMP,
    S_SP_LOW,
    S_SP_REL
  } state_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q, sh_n;

  always_comb begin
    sh_n = sh_q;
    if (load)       sh_n = load_val;
    else if (shift) sh_n = {sh_q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q;
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
  import i2cm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_stb,
  input  logic       rise_stb,
  input  logic       sda_s,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_nak,
  input  logic       sh_msb,
  output logic       sh_load,
  output logic       sh_shift,
  output logic       drive_low,
  output logic       busy,
  output logic       done,
  output logic       ack_rcvd,
  output logic       arb_lost
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  state_t           state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rd_q, rd_n, nak_q, nak_n;
  logic             drv_q, drv_n, done_q, done_n;
  logic             ack_q, ack_n, arb_q, arb_n;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    rd_n     = rd_q;
    nak_n    = nak_q;
    drv_n    = drv_q;
    ack_n    = ack_q;
    arb_n    = arb_q;
    done_n   = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_valid) begin
        cnt_n = '0;
        case (op_t'(cmd_op))
          OP_START: begin state_n = S_ST_REL; arb_n = 1'b0; end
          OP_STOP:  state_n = S_SP_LOW;
          OP_WRITE: begin state_n = S_BIT_SET; rd_n = 1'b0; sh_load = 1'b1; end
          default:  begin state_n = S_BIT_SET; rd_n = 1'b1; nak_n = cmd_nak; end
        endcase
      end
      S_ST_REL: if (fall_stb) begin drv_n = 1'b0; state_n = S_ST_LOW; end
      S_ST_LOW: if (rise_stb) begin drv_n = 1'b1; done_n = 1'b1; state_n = S_IDLE; end
      S_BIT_SET: if (fall_stb) begin
        drv_n   = rd_q ? 1'b0 : !sh_msb;
        state_n = S_BIT_SAMP;
      end
      S_BIT_SAMP: if (rise_stb) begin
        if (!rd_q && !drv_q && !sda_s) begin
          arb_n   = 1'b1;
          drv_n   = 1'b0;
          done_n  = 1'b1;
          state_n = S_IDLE;
        end else begin
          sh_shift = 1'b1;
          if (cnt_q == LAST_BIT) state_n = S_ACK_SET;
          else begin cnt_n = cnt_q + 1'b1; state_n = S_BIT_SET; end
        end
      end
      S_ACK_SET: if (fall_stb) begin
        drv_n   = rd_q ? !nak_q : 1'b0;
        state_n = S_ACK_SAMP;
      end
      S_ACK_SAMP: if (rise_stb) begin
        if (!rd_q) ack_n = !sda_s;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      S_SP_LOW: if (fall_stb) begin drv_n = 1'b1; state_n = S_SP_REL; end
      S_SP_REL: if (rise_stb) begin drv_n = 1'b0; done_n = 1'b1; state_n = S_IDLE; end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      nak_q   <= 1'b0;
      drv_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rd_q    <= rd_n;
      nak_q   <= nak_n;
      drv_q   <= drv_n;
      done_q  <= done_n;
      ack_q   <= ack_n;
      arb_q   <= arb_n;
    end
  end

  assign drive_low = drv_q;
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign ack_rcvd  = ack_q;
  assign arb_lost  = arb_q;

  // R3
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q != $past(drv_q)) |->
      ($past(fall_stb) || ($past(rise_stb) &&
       ($past(state_q) == S_ST_LOW || $past(state_q) == S_SP_REL))));

  // R9
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_q) |-> (!drv_q && done_q && state_q == S_IDLE));

  // R10
  arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_q && !(state_q == S_IDLE && cmd_valid && cmd_op == OP_START)) |=> arb_q);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == S_IDLE));

  // R7
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACK_SAMP && rd_q) |-> (drv_q == !nak_q));
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_fall_stb,
  input  logic              scl_rise_stb,
  input  logic              sda_in,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_nak,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              done,
  output logic              ack_rcvd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              arb_lost
);
  logic sda_s, sh_load, sh_shift;
  logic [DATA_W-1:0] sh_q;

  i2cm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
  );

  i2cm_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(cmd_byte),
    .shift(sh_shift), .sin(sda_s), .q(sh_q)
  );

  i2cm_fsm #(.W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fall_stb(scl_fall_stb), .rise_stb(scl_rise_stb),
    .sda_s(sda_s), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_nak(cmd_nak),
    .sh_msb(sh_q[DATA_W-1]), .sh_load(sh_load), .sh_shift(sh_shift),
    .drive_low(sda_drive_low), .busy(busy), .done(done),
    .ack_rcvd(ack_rcvd), .arb_lost(arb_lost)
  );

  assign rx_byte = sh_q;
endmodule

// File: tb/i2c_arb_master_test.sv
module i2c_arb_master_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, fall, rise, cmd_valid, cmd_nak, other_low;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte, rx_byte;
  logic       drive_low, busy, done, ack_rcvd, arb_lost;
  wire        sda_bus = ~(drive_low | other_low);

  i2c_arb_master uut (
    .clk(clk), .rst_n(rst_n), .scl_fall_stb(fall), .scl_rise_stb(rise),
    .sda_in(sda_bus), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_nak(cmd_nak), .sda_drive_low(drive_low), .busy(busy), .done(done),
    .ack_rcvd(ack_rcvd), .rx_byte(rx_byte), .arb_lost(arb_lost)
  );

  int   checks = 0, fails = 0, done_cnt = 0, edge_bad = 0;
  logic seen [0:8];
  logic ss_op = 1'b0;
  logic prev_drv = 1'b0, prev_fall = 1'b0, prev_rise = 1'b0;

  always @(posedge clk) begin
    if (done) done_cnt++;
    if (rst_n && drive_low !== prev_drv && !(prev_fall || (prev_rise && ss_op)))
      edge_bad++;
    prev_drv  <= drive_low;
    prev_fall <= fall;
    prev_rise <= rise;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] b, input logic nak,
                         input logic [8:0] pat, input bit poke);
    bit got = 0;
    int n = 0;
    ss_op = (op == 2'd0 || op == 2'd1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_nak = nak;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!got && n < 12) begin
      other_low = (n < 9) ? pat[n] : 1'b0;
      fall = 1'b1;
      @(negedge clk);
      fall = 1'b0;
      for (int k = 0; k < 5; k++) begin
        if (poke && n == 3 && k == 0) begin cmd_valid = 1'b1; cmd_op = 2'd0; end
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      if (n < 9) seen[n] = sda_bus;
      rise = 1'b1;
      @(negedge clk);
      rise = 1'b0;
      if (done) got = 1;
      repeat (5) @(negedge clk);
      n++;
    end
    other_low = 1'b0;
    ss_op = 1'b0;
  endtask

  function automatic logic [7:0] seen_byte();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = seen[i];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int d0;
    rst_n = 1'b0; fall = 1'b0; rise = 1'b0; cmd_valid = 1'b0; cmd_nak = 1'b0;
    cmd_op = 2'd0; cmd_byte = 8'h00; other_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", {31'd0, drive_low}, 0);
    chk("R1 busy/done/arb in reset", {29'd0, busy, done, arb_lost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {28'd0, drive_low, busy, done, arb_lost}, 0);

    // R2 START
    d0 = done_cnt;
    run_cmd(2'd0, 8'h00, 1'b0, 9'h000, 0);
    chk("R2 sda high at scl rise", {31'd0, seen[0]}, 1);
    chk("R2 drive low after start", {31'd0, drive_low}, 1);
    chk("R11 one done for start", done_cnt - d0, 1);

    // R4 R5 write sweep
    for (int b = 0; b < 256; b++) begin
      logic a;
      a = (b % 3) != 0;
      run_cmd(2'd2, 8'(b), 1'b0, {a, 8'h00}, 0);
      chk("R4 write bits msb first", {24'd0, seen_byte()}, b);
      chk("R5 ninth bit released", {31'd0, seen[8]}, {31'd0, !a});
      chk("R5 ack_rcvd", {31'd0, ack_rcvd}, {31'd0, a});
    end

    // R6 R7 read sweep
    for (int b = 0; b < 256; b++) begin
      logic [7:0] d;
      d = 8'(b);
      run_cmd(2'd3, 8'h00, d[0], {1'b0, ~d[0], ~d[1], ~d[2], ~d[3], ~d[4], ~d[5], ~d[6], ~d[7]}, 0);
      chk("R6 rx_byte", {24'd0, rx_byte}, b);
      chk("R7 read answer bit", {31'd0, seen[8]}, {31'd0, d[0]});
    end

    // R8 STOP
    run_cmd(2'd1, 8'h00, 1'b0, 9'h000, 0);
    chk("R8 sda low at scl rise", {31'd0, seen[0]}, 0);
    chk("R8 released after stop", {31'd0, drive_low}, 0);

    // R9 arbitration loss on bit 2 of 0xA5 (sent 1, bus pulled low)
    run_cmd(2'd0, 8'h00, 1'b0, 9'h000, 0);
    d0 = done_cnt;
    run_cmd(2'd2, 8'hA5, 1'b0, 9'h004, 0);
    chk("R9 arb_lost set", {31'd0, arb_lost}, 1);
    chk("R9 released and idle", {30'd0, drive_low, busy}, 0);
    chk("R9 one done", done_cnt - d0, 1);
    for (int i = 0; i < 3; i++) begin
      fall = 1'b1; @(negedge clk); fall = 1'b0;
      repeat (5) @(negedge clk);
      rise = 1'b1; @(negedge clk); rise = 1'b0;
      chk("R9 remaining bits not driven", {31'd0, sda_bus}, 1);
      repeat (5) @(negedge clk);
    end

    // R10 sticky through write and stop, cleared by start
    run_cmd(2'd2, 8'h5A, 1'b0, 9'h100, 0);
    chk("R10 sticky after write", {31'd0, arb_lost}, 1);
    chk("R10 write still works", {24'd0, seen_byte()}, 8'h5A);
    run_cmd(2'd1, 8'h00, 1'b0, 9'h000, 0);
    chk("R10 sticky after stop", {31'd0, arb_lost}, 1);
    run_cmd(2'd0, 8'h00, 1'b0, 9'h000, 0);
    chk("R10 cleared by start", {31'd0, arb_lost}, 0);

    // R9 low bus on a driven-low bit is not a loss
    run_cmd(2'd2, 8'h00, 1'b0, 9'h1FF, 0);
    chk("R9 no loss on own zero", {31'd0, arb_lost}, 0);
    chk("R9 ack on all-low bus", {31'd0, ack_rcvd}, 1);

    // R11 command while busy ignored
    d0 = done_cnt;
    run_cmd(2'd2, 8'h3C, 1'b0, 9'h100, 1);
    repeat (20) @(negedge clk);
    chk("R11 byte unaffected by poke", {24'd0, seen_byte()}, 8'h3C);
    chk("R11 single done", done_cnt - d0, 1);
    chk("R11 idle and released", {30'd0, busy, drive_low}, 0);

    chk("R3 drive changes only on allowed strobes", edge_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule